// File: doc/BRIEF.md
# Column-Parallel Gray Code Capture Array

This block is the digital back end of a bank of single-slope converters that share one ramp. One shared counter sweeps a Gray-coded count from zero to full scale in step with the ramp, one code per clock. Every column has only a comparator trigger input and its own capture storage. When a column's trigger rises, that column freezes the present code. The code is never held in a data-tracking register. Each bit is kept as two set-only flags: an active-low flag that marks a captured zero and an active-high flag that marks a captured one. The flag that sets first blocks the other. Because the count is Gray coded, a capture that lands on a code transition is off by at most one code.

A conversion starts on a single-cycle start pulse. The start pulse empties every column. A per-column comparator reset empties that column alone. Captured data is read one column at a time: a select index picks a column, and one cycle later the block returns that column's code converted to binary, a valid flag and the raw flag pairs. A column whose trigger never fired reads as full scale.

Top module: `gray_capture_array`

## Requirements
- R1: On the clock edge that samples `startPulse` high, the count restarts at binary 0. On each later edge it advances by one, and `grayCount` shows the count as bin ^ (bin >> 1). Two successive codes differ in exactly one bit.
- R2: After `grayCount` has shown the all-ones binary count (Gray code 1 followed by zeros) for one cycle, the next edge stops the count there, drops `convBusy` and raises `convDone`. `convDone` stays high until the next start.
- R3: A column's trigger passes through a two-flop synchronizer. If the trigger rises between edges e0 and e1, the column captures on edge e3 the code shown during the cycle that precedes e3. That is two counts after the count shown when the trigger rose, and it stays at full scale once the count has stopped.
- R4: After a capture, each bit b of the column has its one-flag (`rdQ1[b]`, high means set) set when code bit b is 1, and its zero-flag (`rdQ0N[b]`, low means set) set when code bit b is 0. Exactly one flag per bit is set, so both `rdQ1` and `rdQ0N` equal the captured Gray code.
- R5: A column captures at most once between clears. Later rising edges of its trigger leave its stored code unchanged.
- R6: An edge that samples `cmpRst[c]` high clears column c: all zero-flags go high and all one-flags go low. The other columns keep their codes. A start pulse clears every column the same way.
- R7: Before its capture, a column's flags stay cleared while the count runs.
- R8: The edge that samples `rdSel` loads `rdBin` (the selected column's code converted from Gray to binary), `rdValid`, `rdQ0N` and `rdQ1`.
- R9: A column that has not captured reads with `rdValid` low, `rdBin` all ones, `rdQ0N` all ones and `rdQ1` all zeros.
- R10: `colValid[c]` is high exactly when every bit of column c has one flag set. `colErr[c]` is high when any bit has both flags set, or when some bits are set and others are not. In normal use it never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Starts a conversion and clears all columns |
| cmpIn | input | NUM_COL | Comparator trigger per column |
| cmpRst | input | NUM_COL | Comparator reset per column; clears that column |
| rdSel | input | $clog2(NUM_COL) | Column index for readout |
| grayCount | output | CNT_W | Shared Gray-coded count |
| convBusy | output | 1 | Count is sweeping |
| convDone | output | 1 | Sweep reached terminal count |
| colValid | output | NUM_COL | Column holds a complete capture |
| colErr | output | NUM_COL | Column flag pairs are inconsistent |
| rdBin | output | CNT_W | Selected column's code converted to binary |
| rdValid | output | 1 | Selected column holds a capture |
| rdQ0N | output | CNT_W | Selected column's zero-flags, active low |
| rdQ1 | output | CNT_W | Selected column's one-flags, active high |

## Verification
The count is due on the same edge that samples the start pulse, and the bench tracks it from the negative edge that follows. A capture lands three edges after the trigger is driven, so every expected code is the tracked count plus two, held at full scale once the count stops. Readout values are due one edge after `rdSel` is set. The bench changes `rdSel` at a negative edge and reads the outputs at the next negative edge. Clears and start pulses are driven at a negative edge, and their effect is checked after the edge that samples them.

// File: rtl/gca_pkg.sv
package gca_pkg;
  // Strobes from control into the capture datapath.
  typedef struct packed {
    logic clrAll;   // empty every column (conversion start)
  } gca_strobe_t;
endpackage

// File: rtl/gca_ctrl.sv
module gca_ctrl #(
  parameter int CNT_W = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startPulse,
  output gca_pkg::gca_strobe_t     strobe,
  output logic [CNT_W-1:0]         grayCount,
  output logic                     convBusy,
  output logic                     convDone
);
  localparam logic [CNT_W-1:0] LAST_BIN = '1;

  logic [CNT_W-1:0] binCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      binCnt   <= '0;
      convBusy <= 1'b0;
      convDone <= 1'b0;
    end else if (startPulse) begin
      binCnt   <= '0;
      convBusy <= 1'b1;
      convDone <= 1'b0;
    end else if (convBusy) begin
      if (binCnt == LAST_BIN) begin
        convBusy <= 1'b0;
        convDone <= 1'b1;
      end else begin
        binCnt <= binCnt + 1'b1;
      end
    end
  end

  // One bit flips per step, so a capture at a transition is off by at most one code.
  assign grayCount     = binCnt ^ (binCnt >> 1);
  assign strobe.clrAll = startPulse;
endmodule

// File: rtl/gca_column.sv
module gca_column #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmpIn,
  input  logic             clr,
  input  logic [CNT_W-1:0] grayCode,
  output logic [CNT_W-1:0] q0N,
  output logic [CNT_W-1:0] q1,
  output logic             valid,
  output logic             err
);
  logic syncA, syncB, syncPrev;
  logic rise, armed;
  logic [CNT_W-1:0] zeroSet, oneSet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      syncA    <= cmpIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign rise  = syncB & ~syncPrev;
  assign armed = (&q0N) & ~(|q1);

  // Per bit: two set-only flags, each blocked by the other.
  for (genvar b = 0; b < CNT_W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        q0N[b] <= 1'b1;
        q1[b]  <= 1'b0;
      end else if (clr) begin
        q0N[b] <= 1'b1;
        q1[b]  <= 1'b0;
      end else if (rise && armed) begin
        if (grayCode[b] && q0N[b]) q1[b] <= 1'b1;
        if (!grayCode[b] && !q1[b]) q0N[b] <= 1'b0;
      end
    end
  end

  assign zeroSet = ~q0N;
  assign oneSet  = q1;
  assign valid   = &(zeroSet ^ oneSet);
  assign err     = (|(zeroSet & oneSet)) | ((|(zeroSet | oneSet)) & ~valid);
endmodule

// File: rtl/gca_datapath.sv
module gca_datapath #(
  parameter int CNT_W   = 10,
  parameter int NUM_COL = 8,
  parameter int COL_W   = $clog2(NUM_COL)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  gca_pkg::gca_strobe_t            strobe,
  input  logic [CNT_W-1:0]                grayCount,
  input  logic [NUM_COL-1:0]              cmpIn,
  input  logic [NUM_COL-1:0]              cmpRst,
  input  logic [COL_W-1:0]                rdSel,
  output logic [NUM_COL-1:0]              colClr,
  output logic [NUM_COL-1:0][CNT_W-1:0]   colQ0N,
  output logic [NUM_COL-1:0][CNT_W-1:0]   colQ1,
  output logic [NUM_COL-1:0]              colValid,
  output logic [NUM_COL-1:0]              colErr,
  output logic [CNT_W-1:0]                rdBin,
  output logic                            rdValid,
  output logic [CNT_W-1:0]                rdQ0N,
  output logic [CNT_W-1:0]                rdQ1
);
  assign colClr = cmpRst | {NUM_COL{strobe.clrAll}};

  for (genvar c = 0; c < NUM_COL; c++) begin : g_col
    gca_column #(.CNT_W(CNT_W)) u_col (
      .clk     (clk),
      .rstN    (rstN),
      .cmpIn   (cmpIn[c]),
      .clr     (colClr[c]),
      .grayCode(grayCount),
      .q0N     (colQ0N[c]),
      .q1      (colQ1[c]),
      .valid   (colValid[c]),
      .err     (colErr[c])
    );
  end

  logic             selInRange;
  logic [CNT_W-1:0] selQ0N, selQ1, selBin;
  logic             selValid;

  assign selInRange = (int'(rdSel) < NUM_COL);

  always_comb begin
    selQ0N   = '1;
    selQ1    = '0;
    selValid = 1'b0;
    if (selInRange) begin
      selQ0N   = colQ0N[rdSel];
      selQ1    = colQ1[rdSel];
      selValid = colValid[rdSel];
    end
    selBin[CNT_W-1] = selQ1[CNT_W-1];
    for (int b = CNT_W - 2; b >= 0; b--) selBin[b] = selBin[b+1] ^ selQ1[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdBin   <= '1;
      rdValid <= 1'b0;
      rdQ0N   <= '1;
      rdQ1    <= '0;
    end else begin
      rdBin   <= selValid ? selBin : '1;
      rdValid <= selValid;
      rdQ0N   <= selQ0N;
      rdQ1    <= selQ1;
    end
  end
endmodule

// File: rtl/gray_capture_array.sv
module gray_capture_array #(
  parameter int CNT_W   = 10,
  parameter int NUM_COL = 8,
  parameter int COL_W   = $clog2(NUM_COL)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic [NUM_COL-1:0] cmpIn,
  input  logic [NUM_COL-1:0] cmpRst,
  input  logic [COL_W-1:0]   rdSel,
  output logic [CNT_W-1:0]   grayCount,
  output logic               convBusy,
  output logic               convDone,
  output logic [NUM_COL-1:0] colValid,
  output logic [NUM_COL-1:0] colErr,
  output logic [CNT_W-1:0]   rdBin,
  output logic               rdValid,
  output logic [CNT_W-1:0]   rdQ0N,
  output logic [CNT_W-1:0]   rdQ1
);
  gca_pkg::gca_strobe_t                strobe;
  logic [NUM_COL-1:0]                  colClr;
  logic [NUM_COL-1:0][CNT_W-1:0]       colQ0N;
  logic [NUM_COL-1:0][CNT_W-1:0]       colQ1;

  gca_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .strobe    (strobe),
    .grayCount (grayCount),
    .convBusy  (convBusy),
    .convDone  (convDone)
  );

  gca_datapath #(.CNT_W(CNT_W), .NUM_COL(NUM_COL), .COL_W(COL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .grayCount(grayCount),
    .cmpIn    (cmpIn),
    .cmpRst   (cmpRst),
    .rdSel    (rdSel),
    .colClr   (colClr),
    .colQ0N   (colQ0N),
    .colQ1    (colQ1),
    .colValid (colValid),
    .colErr   (colErr),
    .rdBin    (rdBin),
    .rdValid  (rdValid),
    .rdQ0N    (rdQ0N),
    .rdQ1     (rdQ1)
  );
endmodule

// File: rtl/gca_checker.sv
module gca_checker #(
  parameter int CNT_W   = 10,
  parameter int NUM_COL = 8
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          startPulse,
  input logic [CNT_W-1:0]              grayCount,
  input logic                          convBusy,
  input logic                          convDone,
  input logic [NUM_COL-1:0]            colErr,
  input logic [NUM_COL-1:0]            colValid,
  input logic [NUM_COL-1:0]            colClr,
  input logic [NUM_COL-1:0][CNT_W-1:0] colQ0N,
  input logic [NUM_COL-1:0][CNT_W-1:0] colQ1
);
  localparam logic [CNT_W-1:0] LAST_GRAY = {1'b1, {(CNT_W-1){1'b0}}};

  AST_GRAY_ONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    convBusy && $past(convBusy) && !$past(startPulse) |-> $countones(grayCount ^ $past(grayCount)) == 1); // R1

  AST_DONE_AT_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convDone) |-> (grayCount == LAST_GRAY) && !convBusy); // R2

  AST_NO_RAIL_CONFLICT: assert property (@(posedge clk) disable iff (!rstN)
    colErr == '0); // R10

  for (genvar c = 0; c < NUM_COL; c++) begin : g_chk
    AST_HOLD_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
      colValid[c] && !colClr[c] |=> $stable(colQ1[c]) && $stable(colQ0N[c])); // R5

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
      colClr[c] |=> !colValid[c] && (&colQ0N[c]) && !(|colQ1[c])); // R6
  end
endmodule

bind gray_capture_array gca_checker #(.CNT_W(CNT_W), .NUM_COL(NUM_COL)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startPulse(startPulse),
  .grayCount (grayCount),
  .convBusy  (convBusy),
  .convDone  (convDone),
  .colErr    (colErr),
  .colValid  (colValid),
  .colClr    (colClr),
  .colQ0N    (colQ0N),
  .colQ1     (colQ1)
);

// File: tb/sim_gray_capture_array.sv
module sim_gray_capture_array;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;
  localparam int NC = 8;
  localparam int SW = $clog2(NC);
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic [NC-1:0] cmpIn = '0;
  logic [NC-1:0] cmpRst = '0;
  logic [SW-1:0] rdSel = '0;
  logic [CW-1:0] grayCount, rdBin, rdQ0N, rdQ1;
  logic convBusy, convDone, rdValid;
  logic [NC-1:0] colValid, colErr;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gray_capture_array #(.CNT_W(CW), .NUM_COL(NC)) u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .cmpIn(cmpIn), .cmpRst(cmpRst),
    .rdSel(rdSel), .grayCount(grayCount), .convBusy(convBusy), .convDone(convDone),
    .colValid(colValid), .colErr(colErr), .rdBin(rdBin), .rdValid(rdValid),
    .rdQ0N(rdQ0N), .rdQ1(rdQ1)
  );

  function automatic logic [CW-1:0] toGray(int v);
    logic [CW-1:0] b = CW'(v);
    return b ^ (b >> 1);
  endfunction

  function automatic int fromGray(logic [CW-1:0] g);
    int r = 0;
    for (int b = CW - 1; b >= 0; b--) r = (r << 1) | (((r & 1) ^ int'(g[b])) & 1);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic startConv();
    @(negedge clk) startPulse = 1'b1;
    @(negedge clk) startPulse = 1'b0;
  endtask

  task automatic waitCount(input int v);
    while (fromGray(grayCount) < v) @(negedge clk);
  endtask

  task automatic readCol(input int c);
    @(negedge clk) rdSel = SW'(c);
    @(negedge clk);
  endtask

  task automatic expectCaptured(input int c, input int v, input string req);
    readCol(c);
    check(rdValid === 1'b1, {req, " valid"}, rdValid, 1);
    check(rdBin === CW'(v), {req, " binary"}, rdBin, v);
    check(rdQ1 === toGray(v), "R4 one-flags", rdQ1, toGray(v));
    check(rdQ0N === toGray(v), "R4 zero-flags active low", rdQ0N, toGray(v));
  endtask

  task automatic expectEmpty(input int c, input string req);
    readCol(c);
    check(rdValid === 1'b0, {req, " valid low"}, rdValid, 0);
    check(rdBin === '1, {req, " full scale"}, rdBin, MAXV);
    check(rdQ0N === '1 && rdQ1 === '0, {req, " flags clear"}, {rdQ0N, rdQ1}, {CW'(MAXV), CW'(0)});
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(grayCount === '0 && convBusy === 1'b0 && convDone === 1'b0, "R1 reset count",
          {grayCount, convBusy, convDone}, 0);
    check(colValid === '0 && colErr === '0, "R10 reset flags", {colValid, colErr}, 0);
    expectEmpty(0, "R9 reset readout");
  endtask

  // Full sweep: Gray sequence and terminal behaviour.
  task automatic t_sweep();
    int bad = 0;
    startConv();
    for (int i = 0; i <= MAXV; i++) begin
      if (grayCount !== toGray(i) || convBusy !== 1'b1) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R1 gray sequence", bad, 0);
    check(convDone === 1'b1 && convBusy === 1'b0, "R2 done raised", {convDone, convBusy}, 2);
    check(grayCount === toGray(MAXV), "R2 count holds", grayCount, toGray(MAXV));
    repeat (3) @(negedge clk);
    check(convDone === 1'b1 && grayCount === toGray(MAXV), "R2 done held", convDone, 1);
  endtask

  // Captures at several points, refire, untouched columns, readout.
  task automatic t_capture();
    startConv();
    cmpIn[2] = 1'b1;                      // count 0 -> captures 2
    waitCount(5);  cmpIn[0] = 1'b1;       // captures 7
    waitCount(100);
    readCol(1);
    check(rdValid === 1'b0 && rdQ0N === '1 && rdQ1 === '0, "R7 no tracking before capture",
          {rdQ0N, rdQ1}, {CW'(MAXV), CW'(0)});
    expectCaptured(0, 7, "R3 capture count+2");
    waitCount(150); cmpIn[0] = 1'b0;
    waitCount(200); cmpIn[0] = 1'b1;      // second rise ignored
    waitCount(300); cmpIn[1] = 1'b1;      // captures 302
    waitCount(MAXV - 1); cmpIn[3] = 1'b1; // captures full scale
    while (!convDone) @(negedge clk);
    repeat (4) @(negedge clk);
    expectCaptured(0, 7, "R5 refire ignored");
    expectCaptured(1, 302, "R8 readout mid code");
    expectCaptured(2, 2, "R3 capture at start");
    expectCaptured(3, MAXV, "R3 capture saturates");
    expectEmpty(6, "R9 never fired");
    check(colValid === 8'b0000_1111, "R10 column valid", colValid, 8'h0f);
    check(colErr === '0, "R10 no error", colErr, 0);
  endtask

  task automatic t_clear();
    cmpIn[1] = 1'b0;
    @(negedge clk) cmpRst[1] = 1'b1;
    @(negedge clk) cmpRst[1] = 1'b0;
    expectEmpty(1, "R6 column clear");
    expectCaptured(0, 7, "R6 neighbour kept");
  endtask

  task automatic t_restart();
    cmpIn = '0;
    repeat (4) @(negedge clk);
    startConv();
    check(colValid === '0, "R6 start clears all", colValid, 0);
    expectEmpty(3, "R6 start clears column");
    while (!convDone) @(negedge clk);
    cmpIn[5] = 1'b1;                      // after done: count frozen at full scale
    repeat (4) @(negedge clk);
    expectCaptured(5, MAXV, "R3 capture after done");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_sweep();
    t_capture();
    t_clear();
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule